// File: doc/BRIEF.md
# Daisy-Chained Central Bus Arbiter

This block decides which master may drive a shared bus. The processor is the default owner. Behind it sit four DMA masters arranged along a grant chain. Every DMA master that wants the bus adds its request to one shared request line. The central controller answers by raising a single grant. The grant enters the chain at the master nearest the controller. A master that has no request lets the grant pass to the next master. The first requesting master keeps the grant for itself, so position alone sets priority.

Mastership moves through one shared active-low busy line. The current owner frees the bus by letting busy return high. The granted master waits until it holds the grant while busy is high. At that edge it pulls busy low and withdraws its request. Each DMA master then keeps the bus for a tenure set by a parameter and releases it. If nobody is waiting at that point, the processor takes the bus back.

Top module: `chain_bus_arbiter`

## Requirements
- R1: `bus_req` is high exactly when at least one DMA master has a captured, unserved request. A one-cycle pulse on `dma_want[i]` is captured at the clock edge where it is seen.
- R2: When the controller is idle and `bus_req` is high at a clock edge, `bus_grant` goes high after that edge, and never without a prior request.
- R3: Index 0 is nearest the controller. `grant_tap[j]` is high when the grant reaches master j. Among pending masters, the lowest index absorbs the grant and wins, including when its request arrives after a higher-index request but before that request has taken the bus.
- R4: A DMA master takes the bus only at an edge where it holds the grant and `busy_n` is high. At that same edge its `dma_own` bit rises, `busy_n` goes low and its request is withdrawn.
- R5: After reset the processor owns the bus (`cpu_own` high, `busy_n` low). It gives the bus up at the first edge at which it sees `bus_grant` high.
- R6: After a handover, `bus_grant` falls at the edge after `busy_n` returns low. A new grant follows only for a further request.
- R7: DMA master i keeps the bus for HOLD_MIN + i*HOLD_STEP cycles, which gives 3, 5, 7 and 9 cycles by default. After that it releases `busy_n` to high.
- R8: When `busy_n` is high and `bus_req` is low at an edge, the processor owns the bus after that edge. While a request is pending, the processor does not take it back.
- R9: At most one of `cpu_own` and `dma_own` is high in any cycle. `busy_n` is low exactly when one of them is high.
- R10: A `dma_want` pulse from a master that currently owns the bus is ignored. It raises no request and causes no second tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_want | input | N_DMA | Per-master request pulse, captured at the edge where it is seen |
| bus_req | output | 1 | Shared request line: OR of all pending requests |
| bus_grant | output | 1 | Grant driven by the controller into chain position 0 |
| grant_tap | output | N_DMA | Grant as seen at the input of each chain position |
| grant_tail | output | 1 | Grant that passed every chain position unclaimed |
| busy_n | output | 1 | Shared active-low busy line |
| cpu_own | output | 1 | Processor currently owns the bus |
| dma_own | output | N_DMA | One bit per DMA master currently owning the bus |

## Verification
Two functions can land in the same cycle. The first pair is a late request from a higher-priority master and the processor's release of the bus. The bench provokes it by pulsing master 0 one cycle after master 2 has received the grant. Master 0 must then take the bus at the edge where busy first reads high, and master 2 must follow only after master 0's full tenure. The second pair is the end of one DMA tenure and the re-offered grant reaching the next pending master. The bench checks that the second master takes the bus exactly one edge after the first releases, and that the processor never slips in between.

// File: rtl/arb_chain_pkg.sv
package arb_chain_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE   = 2'd0,
    ARB_OFFER  = 2'd1,
    ARB_SETTLE = 2'd2
  } arb_state_e;

  function automatic int unsigned tenure_of(input int unsigned base,
                                            input int unsigned step,
                                            input int unsigned idx);
    return base + step * idx;
  endfunction

endpackage

// File: rtl/arb_grant_ctrl.sv
module arb_grant_ctrl
  import arb_chain_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_any,
  input  logic busy_n,
  output logic grant
);

  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE:   if (req_any) state_d = ARB_OFFER;
      // hold the grant until the bus is seen free
      ARB_OFFER:  if (busy_n)  state_d = ARB_SETTLE;
      // the new owner has pulled busy low: withdraw
      ARB_SETTLE: if (!busy_n) state_d = ARB_IDLE;
      default:    state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ARB_IDLE;
    else        state_q <= state_d;
  end

  assign grant = (state_q != ARB_IDLE);

endmodule

// File: rtl/arb_cpu_seat.sv
module arb_cpu_seat (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic req_any,
  input  logic busy_n,
  output logic own
);

  always_ff @(posedge clk) begin
    if (!rst_n)                           own <= 1'b1;
    else if (own && grant)                own <= 1'b0;
    else if (!own && busy_n && !req_any)  own <= 1'b1;
  end

endmodule

// File: rtl/arb_chain_cell.sv
module arb_chain_cell #(
  parameter int unsigned HOLD  = 3,
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic grant_in,
  input  logic busy_n,
  output logic grant_out,
  output logic req,
  output logic own
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             take;

  assign take      = pend_q && grant_in && busy_n;
  assign grant_out = grant_in && !pend_q;
  assign req       = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      own    <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (take)              pend_q <= 1'b0;
      else if (want && !own) pend_q <= 1'b1;

      if (take) begin
        own   <= 1'b1;
        cnt_q <= LAST;
      end else if (own) begin
        if (cnt_q == '0) own   <= 1'b0;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/chain_bus_arbiter.sv
module chain_bus_arbiter
  import arb_chain_pkg::*;
#(
  parameter int unsigned N_DMA     = 4,
  parameter int unsigned HOLD_MIN  = 3,
  parameter int unsigned HOLD_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DMA-1:0] dma_want,
  output logic             bus_req,
  output logic             bus_grant,
  output logic [N_DMA-1:0] grant_tap,
  output logic             grant_tail,
  output logic             busy_n,
  output logic             cpu_own,
  output logic [N_DMA-1:0] dma_own
);

  localparam int unsigned MAX_HOLD = HOLD_MIN + HOLD_STEP * (N_DMA - 1);
  localparam int unsigned CNT_W    = $clog2(MAX_HOLD + 1);

  logic [N_DMA:0]   chain;
  logic [N_DMA-1:0] pend;

  assign chain[0]   = bus_grant;
  assign grant_tap  = chain[N_DMA-1:0];
  assign grant_tail = chain[N_DMA];
  assign bus_req    = |pend;
  assign busy_n     = !(cpu_own || (|dma_own));

  arb_grant_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_any (bus_req),
    .busy_n  (busy_n),
    .grant   (bus_grant)
  );

  arb_cpu_seat u_cpu (
    .clk     (clk),
    .rst_n   (rst_n),
    .grant   (bus_grant),
    .req_any (bus_req),
    .busy_n  (busy_n),
    .own     (cpu_own)
  );

  for (genvar i = 0; i < N_DMA; i++) begin : g_cell
    arb_chain_cell #(
      .HOLD  (tenure_of(HOLD_MIN, HOLD_STEP, i)),
      .CNT_W (CNT_W)
    ) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .want      (dma_want[i]),
      .grant_in  (chain[i]),
      .busy_n    (busy_n),
      .grant_out (chain[i+1]),
      .req       (pend[i]),
      .own       (dma_own[i])
    );
  end

endmodule

// File: rtl/chain_bus_arbiter_chk.sv
module chain_bus_arbiter_chk #(
  parameter int unsigned N_DMA = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req,
  input logic             bus_grant,
  input logic             busy_n,
  input logic             cpu_own,
  input logic [N_DMA-1:0] dma_own
);

  a_r9_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cpu_own, dma_own}) <= 1);

  a_r4_take_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dma_own & ~$past(dma_own))) |-> ($past(bus_grant) && $past(busy_n)));

  a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_grant) |-> $past(bus_req));

  a_r6_grant_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_grant) && $past(busy_n) && bus_grant && !busy_n) |=> !bus_grant);

  a_r5_cpu_yields: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_own && bus_grant) |=> !cpu_own);

  a_r8_cpu_back: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && !bus_req) |=> cpu_own);

endmodule

bind chain_bus_arbiter chain_bus_arbiter_chk #(.N_DMA(N_DMA)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_grant (bus_grant),
  .busy_n    (busy_n),
  .cpu_own   (cpu_own),
  .dma_own   (dma_own)
);

// File: tb/sim_chain_bus_arbiter.sv
module sim_chain_bus_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int NB    = 4;
  localparam int HMIN  = 3;
  localparam int HSTEP = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] dma_want = '0;
  logic          bus_req, bus_grant, grant_tail, busy_n, cpu_own;
  logic [NB-1:0] grant_tap, dma_own;

  int checks = 0;
  int errors = 0;
  int viol   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_bus_arbiter #(.N_DMA(NB), .HOLD_MIN(HMIN), .HOLD_STEP(HSTEP)) u0 (
    .clk(clk), .rst_n(rst_n), .dma_want(dma_want), .bus_req(bus_req),
    .bus_grant(bus_grant), .grant_tap(grant_tap), .grant_tail(grant_tail),
    .busy_n(busy_n), .cpu_own(cpu_own), .dma_own(dma_own)
  );

  function automatic int hold(input int i);
    return HMIN + HSTEP * i;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // R9 monitor: exclusive ownership and busy line agreement
  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones({cpu_own, dma_own}) > 1) viol++;
      if (busy_n !== !(cpu_own || (|dma_own))) viol++;
    end
  end

  task automatic t_reset();
    chk("R5 reset cpu_own", int'(cpu_own), 1);
    chk("R5 reset busy_n", int'(busy_n), 0);
    chk("R1 reset bus_req", int'(bus_req), 0);
    chk("R2 reset bus_grant", int'(bus_grant), 0);
    chk("R9 reset dma_own", int'(dma_own), 0);
  endtask

  task automatic t_single(input int i);
    step();
    dma_want = NB'(1) << i;
    step();                                   // after E0
    dma_want = '0;
    chk("R1 req raised", int'(bus_req), 1);
    chk("R2 no grant yet", int'(bus_grant), 0);
    step();                                   // after E1
    chk("R2 grant up", int'(bus_grant), 1);
    chk("R3 grant taps", int'(grant_tap), (1 << (i + 1)) - 1);
    chk("R5 cpu still owns", int'(cpu_own), 1);
    step();                                   // after E2
    chk("R5 cpu released", int'(cpu_own), 0);
    chk("R5 busy free", int'(busy_n), 1);
    step();                                   // after E3
    chk("R4 owner", int'(dma_own), 1 << i);
    chk("R4 busy low", int'(busy_n), 0);
    chk("R4 req dropped", int'(bus_req), 0);
    step();                                   // after E4
    chk("R6 grant dropped", int'(bus_grant), 0);
    repeat (hold(i) - 2) step();
    chk("R7 still owns", int'(dma_own), 1 << i);
    step();
    chk("R7 released", int'(dma_own), 0);
    chk("R7 busy free", int'(busy_n), 1);
    step();
    chk("R8 cpu back", int'(cpu_own), 1);
    repeat (2) step();
  endtask

  task automatic t_pair(input int a, input int b);
    step();
    dma_want = (NB'(1) << a) | (NB'(1) << b);
    step();
    dma_want = '0;
    repeat (3) step();                        // after E3
    chk("R3 nearer wins", int'(dma_own), 1 << a);
    chk("R1 other pending", int'(bus_req), 1);
    repeat (hold(a)) step();                  // a has released
    chk("R7 first released", int'(dma_own), 0);
    chk("R8 cpu stays off", int'(cpu_own), 0);
    step();
    chk("R4 second takes", int'(dma_own), 1 << b);
    repeat (hold(b) + 1) step();
    chk("R8 cpu back after pair", int'(cpu_own), 1);
    repeat (2) step();
  endtask

  task automatic t_late();
    step();
    dma_want = NB'(4);                        // master 2
    step();                                   // after E0
    dma_want = '0;
    step();                                   // after E1
    dma_want = NB'(1);                        // master 0, late
    step();                                   // after E2
    dma_want = '0;
    chk("R5 busy free at handover", int'(busy_n), 1);
    step();                                   // after E3
    chk("R3 late nearer wins", int'(dma_own), 1);
    repeat (hold(0) + 1) step();
    chk("R3 far master follows", int'(dma_own), 4);
    repeat (hold(2) + 1) step();
    chk("R8 cpu back after late", int'(cpu_own), 1);
    repeat (2) step();
  endtask

  task automatic t_ignore(input int i);
    step();
    dma_want = NB'(1) << i;
    step();
    dma_want = '0;
    repeat (3) step();                        // after E3, owning
    dma_want = NB'(1) << i;
    step();                                   // after E4
    dma_want = '0;
    chk("R10 no new req", int'(bus_req), 0);
    repeat (hold(i) - 2) step();
    step();
    chk("R10 released once", int'(dma_own), 0);
    step();
    chk("R10 cpu back", int'(cpu_own), 1);
    chk("R10 still no req", int'(bus_req), 0);
    repeat (2) step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    for (int i = 0; i < NB; i++) t_single(i);
    t_pair(1, 3);
    t_pair(0, 2);
    t_late();
    t_ignore(1);
    chk("R9 exclusive ownership", viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule